// File: doc/BRIEF.md
# Decoder Status Flag Generator

This block turns internal decoder events into three status pins for a host controller. All three pins sit at logic 1 after reset.

The control-busy pin drops to 0 once the decoder signals that it can accept control messages. The heartbeat pin toggles on a steady rhythm while decoding is healthy. In compressed mode that rhythm is one toggle per detected frame sync. In LPCM mode it is one toggle per block of 1024 sample strobes. A host that sees the heartbeat stop toggling treats it as an error.

The active-low unsync pin reports different things in each mode. In compressed mode it shows whether the decoder is locked to the frame sync. In LPCM mode it shows whether the decoder is still initialising or is already processing. A change of mode resets the sample count and sends the unsync pin back to 1 until the new mode reports sync or processing.

Top module: `dec_status_flags`

## Requirements
- R1: Reset (rst_ni low) drives ctrl_busy_o, beat_o and unsync_o to 1 and clears the LPCM sample count.
- R2: A ready_i pulse makes ctrl_busy_o 0 from the next clock edge. It then stays 0 until reset.
- R3: In compressed mode, beat_o inverts on the edge after each cycle with sync_found_i high, even when sync_lost_i is also high. In all other cycles beat_o holds, and sample_i has no effect on it.
- R4: In compressed mode, unsync_o goes to 0 after sync_found_i and to 1 after sync_lost_i. When both are high in one cycle, sync_lost_i wins (unsync_o goes to 1). With neither high, unsync_o holds.
- R5: In LPCM mode, beat_o inverts on the edge that takes in the 1024th sample_i strobe counted since the mode was entered, and again on every further 1024th strobe. sync_found_i and sync_lost_i have no effect on beat_o in this mode.
- R6: In LPCM mode, unsync_o stays 1 until the first sample_i strobe after the mode was entered, and is 0 from then on. sync_found_i and sync_lost_i do not change it.
- R7: A mode change happens in any cycle where mode_i differs from its value at the previous edge; after reset that previous value counts as compressed. On a mode change the edge sets unsync_o to 1, clears the sample count and holds beat_o. Any sync_found_i, sync_lost_i or sample_i in that cycle is ignored.
- R8: mode_i = 0 selects compressed mode and mode_i = 1 selects LPCM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = compressed, 1 = LPCM |
| ready_i | input | 1 | Pulse: control interface ready |
| sync_found_i | input | 1 | Pulse: frame sync pattern detected |
| sync_lost_i | input | 1 | Pulse: frame sync lost |
| sample_i | input | 1 | Strobe: one LPCM sample processed |
| ctrl_busy_o | output | 1 | 1 until the control interface is ready |
| beat_o | output | 1 | Heartbeat toggle |
| unsync_o | output | 1 | 1 = out of sync / initialising, 0 = synchronised / processing |

## Verification
The hardest situation to reach from the ports is an LPCM heartbeat toggle that has been moved by a mode change. To get there, the stimulus sends several hundred samples, switches to compressed mode and back, and puts events into the switch cycle itself. It then sweeps sample by sample past the 1024 boundary. At every strobe the expected heartbeat comes from the strobe count since the mode was last entered, so a counter that was not cleared, or one that is off by one, shows up at the exact sample where it goes wrong. Long uninterrupted LPCM runs of several 1024 blocks, and a burst of strobes in compressed mode, cover wrap-around and the ignored input.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  typedef enum logic {
    MODE_COMP = 1'b0,
    MODE_LPCM = 1'b1
  } dec_mode_e;

  localparam int unsigned BLOCK_LOG2 = 10;
endpackage

// File: rtl/dsf_mode_track.sv
module dsf_mode_track
  import dsf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  output logic chg_o,
  output logic comp_o,
  output logic lpcm_o
);
  dec_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_COMP;
    else         mode_q <= dec_mode_e'(mode_i);
  end

  assign chg_o  = (dec_mode_e'(mode_i) != mode_q);
  assign comp_o = !chg_o && (dec_mode_e'(mode_i) == MODE_COMP);
  assign lpcm_o = !chg_o && (dec_mode_e'(mode_i) == MODE_LPCM);
endmodule

// File: rtl/dsf_flag.sv
// Reset-high flag; set has priority over clear.
module dsf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b1;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/dsf_beat.sv
module dsf_beat #(
  parameter int unsigned CNT_W = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic frame_i,
  input  logic sample_i,
  output logic beat_o
);
  logic wrap;

  generate
    if (CNT_W == 0) begin : g_nocnt
      assign wrap = sample_i;
    end else begin : g_cnt
      localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       cnt_q <= '0;
        else if (clr_i)    cnt_q <= '0;
        else if (sample_i) cnt_q <= cnt_q + 1'b1;
      end
      assign wrap = sample_i && (cnt_q == CNT_MAX);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       beat_o <= 1'b1;
    else if (!clr_i && (frame_i || wrap)) beat_o <= !beat_o;
  end
endmodule

// File: rtl/dec_status_flags.sv
module dec_status_flags #(
  parameter int unsigned CNT_W = dsf_pkg::BLOCK_LOG2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic ready_i,
  input  logic sync_found_i,
  input  logic sync_lost_i,
  input  logic sample_i,
  output logic ctrl_busy_o,
  output logic beat_o,
  output logic unsync_o
);
  logic mode_chg, in_comp, in_lpcm;
  logic sync_set, sync_clr;

  dsf_mode_track u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .chg_o  (mode_chg),
    .comp_o (in_comp),
    .lpcm_o (in_lpcm)
  );

  dsf_flag u_ready (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (1'b0),
    .clr_i  (ready_i),
    .flag_o (ctrl_busy_o)
  );

  // Mode change and lost sync both force the flag high; lost wins over found.
  assign sync_set = mode_chg || (in_comp && sync_lost_i);
  assign sync_clr = (in_comp && sync_found_i) || (in_lpcm && sample_i);

  dsf_flag u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sync_set),
    .clr_i  (sync_clr),
    .flag_o (unsync_o)
  );

  dsf_beat #(.CNT_W(CNT_W)) u_beat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (mode_chg),
    .frame_i  (in_comp && sync_found_i),
    .sample_i (in_lpcm && sample_i),
    .beat_o   (beat_o)
  );
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_i,
  input logic ready_i,
  input logic sync_found_i,
  input logic sync_lost_i,
  input logic sample_i,
  input logic ctrl_busy_o,
  input logic beat_o,
  input logic unsync_o
);
  logic prev_mode;
  logic steady;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_mode <= 1'b0;
    else         prev_mode <= mode_i;
  end
  assign steady = (mode_i == prev_mode);

  // R2
  ready_clears_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> !ctrl_busy_o);

  // R2
  busy_never_returns_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_busy_o |=> !ctrl_busy_o);

  // R3
  comp_beat_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && !mode_i && sync_found_i) |=> (beat_o != $past(beat_o)));

  // R3
  beat_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_found_i && !sample_i) |=> $stable(beat_o));

  // R4
  comp_lost_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && !mode_i && sync_lost_i) |=> unsync_o);

  // R4
  comp_found_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && !mode_i && sync_found_i && !sync_lost_i) |=> !unsync_o);

  // R6
  lpcm_proc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && mode_i && sample_i) |=> !unsync_o);

  // R7
  mode_chg_unsync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !steady |=> (unsync_o && $stable(beat_o)));
endmodule

bind dec_status_flags dsf_checker u_chk (.*);

// File: tb/dec_status_flags_test.sv
`timescale 1ns/1ps
module dec_status_flags_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, rdy = 1'b0, sf = 1'b0, sl = 1'b0, smp = 1'b0;
  logic busy, beat, unsync;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = !clk;

  dec_status_flags uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ready_i(rdy),
    .sync_found_i(sf), .sync_lost_i(sl), .sample_i(smp),
    .ctrl_busy_o(busy), .beat_o(beat), .unsync_o(unsync)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle of inputs, then sample just after the edge.
  task automatic step(input logic m, input logic r, input logic f,
                      input logic l, input logic s);
    @(negedge clk);
    mode = m; rdy = r; sf = f; sl = l; smp = s;
    @(posedge clk);
    #1;
    rdy = 1'b0; sf = 1'b0; sl = 1'b0; smp = 1'b0;
  endtask

  logic exp_beat;

  initial begin
    #20;
    chk("R1 busy", busy, 1'b1);
    chk("R1 beat", beat, 1'b1);
    chk("R1 unsync", unsync, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    exp_beat = 1'b1;

    // R2: busy holds until ready, then stays low
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 busy before ready", busy, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 busy after ready", busy, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 busy held", busy, 1'b0);

    // R3/R4: sync pulses with varying gaps
    for (int n = 1; n <= 24; n++) begin
      for (int g = 0; g < n % 5; g++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      exp_beat = !exp_beat;
      chk("R3 comp beat", beat, exp_beat);
      chk("R4 found", unsync, 1'b0);
    end
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4 lost", unsync, 1'b1);
    chk("R3 lost no beat", beat, exp_beat);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    exp_beat = !exp_beat;
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    exp_beat = !exp_beat;
    chk("R4 both lost wins", unsync, 1'b1);
    chk("R3 both toggles", beat, exp_beat);
    // R3: samples ignored in compressed mode
    for (int i = 0; i < 2100; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 samples ignored", beat, exp_beat);
    chk("R4 hold unsync", unsync, 1'b1);

    // R7/R8: switch to LPCM with events in the switch cycle
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R7 switch unsync", unsync, 1'b1);
    chk("R7 switch beat held", beat, exp_beat);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R5 found ignored beat", beat, exp_beat);
    chk("R6 init unsync", unsync, 1'b1);
    // R5/R6: three full blocks, every strobe checked
    for (int k = 1; k <= 3 * 1024; k++) begin
      if (k % 7 == 0) step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      if (k % 1024 == 0) exp_beat = !exp_beat;
      chk("R5 lpcm beat", beat, exp_beat);
      chk("R6 processing", unsync, 1'b0);
    end

    // R7: partial block, leave and re-enter, count restarts
    for (int k = 0; k < 500; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 to comp unsync", unsync, 1'b1);
    chk("R7 to comp beat held", beat, exp_beat);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 comp waits sync", unsync, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 back lpcm unsync", unsync, 1'b1);
    for (int k = 1; k <= 1100; k++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      if (k == 1024) exp_beat = !exp_beat;
      chk("R7 recount beat", beat, exp_beat);
    end

    // R1: reset mid-run restores all flags
    @(negedge clk); rst_n = 1'b0;
    #2;
    chk("R1 busy rst", busy, 1'b1);
    chk("R1 unsync rst", unsync, 1'b1);
    @(negedge clk); rst_n = 1'b1; mode = 1'b1;
    exp_beat = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1); // mode change vs reset value
    for (int k = 1; k <= 1024; k++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      if (k == 1024) exp_beat = !exp_beat;
    end
    chk("R1 count cleared by reset", beat, exp_beat);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule